// File: doc/BRIEF.md
# AC-link Modem Output Frame Serializer

This block sits on the controller side of a 20-bit-slot serial codec link. It runs on the link's bit clock and shifts out one output frame every 256 bit clocks. Each frame is a 16-bit tag slot followed by twelve 20-bit data slots, sent most significant bit first. A frame marker, `sync`, is high while the tag slot is on the wire.

Only the modem slots carry data. Slot 1 holds the command address, slot 2 the command write data, slot 5 the line 1 DAC sample, slot 10 the line 2 DAC sample and slot 12 the GPIO control word. Every other slot is sent as zeros. The sample, GPIO and command inputs are captured on the last bit clock of each frame and are then held for the whole next frame.

A register command is offered with `cmd_valid`. Once the frame that carries it has gone out, the block acknowledges it with a one-cycle `cmd_ack` pulse. The requester is expected to drop `cmd_valid` when it sees that pulse.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame is 256 bits: a 16-bit tag slot, then slots 1 to 12 of 20 bits each, each sent MSB first, one bit per clock. `sync` is high for exactly the 16 tag bits and low for the other 240.
- R2: In the tag, bit 15 (frame valid) is always 1. Bits 10, 5 and 3 (slots 5, 10 and 12 valid) are always 1. Bit 14 (slot 1 valid) is 1 only when the frame carries a command. Bit 13 (slot 2 valid) is 1 only when that command is a write. All other tag bits are 0.
- R3: Slot 1 carries the command's read flag in bit 19 (1 = read, 0 = write) and its 7-bit register address in bits 18..12. Bits 11..0 are zero.
- R4: Slot 2 carries the 16-bit write data in bits 19..4 for a write and all zeros for a read. Bits 3..0 are always zero.
- R5: Slot 5 carries the line 1 DAC sample and slot 10 the line 2 DAC sample. In each, the sample's MSB is in bit 19 and its LSB in bit 4, and bits 3..0 are zero.
- R6: Slot 12 carries the 16-bit GPIO control word in bits 19..4, with word bit 0 in slot bit 4, so the line 1 controls sit below the line 2 controls. Bits 3..0 are zero.
- R7: Slots 3, 4, 6, 7, 8, 9 and 11 are always all zeros. Slots 1 and 2 are all zeros in a frame that carries no command.
- R8: The inputs are captured on the last bit clock of a frame and set the content of the next frame. Changes made during a frame do not alter the frame being sent.
- R9: A command offered with `cmd_valid` on the last bit clock of a frame is sent in the next frame. `cmd_ack` is high for exactly one cycle, together with the final bit of that frame, and is low at all other times.
- R10: On the last bit clock of a frame that carries a command, `cmd_valid` is ignored. The next frame carries no command and its slot 1 and slot 2 tags are 0.
- R11: While `rst_n` is low, `sync`, `sdata` and `cmd_ack` are low. The first frame after reset carries no command and all-zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A register command is offered |
| cmd_rd | input | 1 | 1 = read command, 0 = write command |
| cmd_addr | input | 7 | Target register address |
| cmd_wdata | input | 16 | Write data |
| line1_dac | input | 16 | Line 1 DAC sample |
| line2_dac | input | 16 | Line 2 DAC sample |
| gpio_word | input | 16 | GPIO control word for slot 12 |
| cmd_ack | output | 1 | The command frame has been sent (pulse) |
| sync | output | 1 | Frame marker, high during the tag slot |
| sdata | output | 1 | Serial output data |

## Verification
Several properties are checked on every clock. The timer must wrap from the last bit of slot 12 to the top of the tag. The padding bits of the command address slot and the unused audio slots must always be zero, and slot 2 must be zero for a read. No command may be accepted at a boundary that ends a command frame, and every acknowledge must be followed by the start of a new frame. Other behaviour can only be shown by the bench, which rebuilds whole frames and compares every slot: correct placement and justification of each sample and field, correct tag bits for write, read and empty frames, the capture point of the inputs, and the ignored command at the acknowledge boundary.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int SMP_W      = 16;
  localparam int ADDR_W     = 7;
  localparam int SLOT_IDX_W = $clog2(N_SLOTS + 1);
  localparam int BIT_IDX_W  = $clog2(SLOT_W);
  localparam int PAD_W      = SLOT_W - SMP_W;
  localparam int CMD_PAD_W  = SLOT_W - 1 - ADDR_W;

  // slot positions used by the modem function
  localparam int SL_CMD_ADDR = 1;
  localparam int SL_CMD_DATA = 2;
  localparam int SL_LINE1    = 5;
  localparam int SL_LINE2    = 10;
  localparam int SL_GPIO     = 12;

  typedef logic [SLOT_W-1:0] slot_word_t;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx,
  output logic                  frame_last
);
  logic [SLOT_IDX_W-1:0] slot_d;
  logic [BIT_IDX_W-1:0]  bit_d;

  assign frame_last = (slot_idx == SLOT_IDX_W'(N_SLOTS)) && (bit_idx == '0);

  always_comb begin
    slot_d = slot_idx;
    bit_d  = bit_idx - BIT_IDX_W'(1);
    if (bit_idx == '0) begin
      if (frame_last) begin
        slot_d = '0;
        bit_d  = BIT_IDX_W'(TAG_W - 1);
      end else begin
        slot_d = slot_idx + SLOT_IDX_W'(1);
        bit_d  = BIT_IDX_W'(SLOT_W - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0;
      bit_idx  <= BIT_IDX_W'(TAG_W - 1);
    end else begin
      slot_idx <= slot_d;
      bit_idx  <= bit_d;
    end
  end

  // R1: the last bit of slot 12 is followed by the top bit of the tag
  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (slot_idx == '0) && (bit_idx == BIT_IDX_W'(TAG_W - 1)));

  // R1: every slot is entered at its top bit
  a_r1_slot_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != $past(slot_idx)) && (slot_idx != '0) |-> bit_idx == BIT_IDX_W'(SLOT_W - 1));
endmodule

// File: rtl/aclink_slot_mux.sv
module aclink_slot_mux
  import aclink_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  cmd_valid,
  input  logic                  cmd_rd,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [SMP_W-1:0]      cmd_wdata,
  input  logic [SMP_W-1:0]      line1_dac,
  input  logic [SMP_W-1:0]      line2_dac,
  input  logic [SMP_W-1:0]      gpio_word,
  input  logic [SLOT_IDX_W-1:0] slot_idx,
  input  logic [BIT_IDX_W-1:0]  bit_idx,
  output logic                  bit_nxt,
  output logic                  cmd_in_frame
);
  // frame snapshot, captured on the last bit clock
  logic              snap_cmd_q, snap_rd_q;
  logic [ADDR_W-1:0] snap_addr_q;
  logic [SMP_W-1:0]  snap_wd_q, snap_l1_q, snap_l2_q, snap_gp_q;
  logic              accept;

  slot_word_t        words [N_SLOTS+1];
  logic [N_SLOTS:1]  slot_vld;

  assign accept       = load && cmd_valid && !snap_cmd_q;
  assign cmd_in_frame = snap_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cmd_q  <= 1'b0;
      snap_rd_q   <= 1'b0;
      snap_addr_q <= '0;
      snap_wd_q   <= '0;
      snap_l1_q   <= '0;
      snap_l2_q   <= '0;
      snap_gp_q   <= '0;
    end else if (load) begin
      snap_cmd_q  <= accept;
      snap_rd_q   <= accept && cmd_rd;
      snap_addr_q <= accept ? cmd_addr : '0;
      snap_wd_q   <= (accept && !cmd_rd) ? cmd_wdata : '0;
      snap_l1_q   <= line1_dac;
      snap_l2_q   <= line2_dac;
      snap_gp_q   <= gpio_word;
    end
  end

  // slot valid flags and slot contents, one per slot position
  for (genvar n = 1; n <= N_SLOTS; n++) begin : g_slot
    always_comb begin
      slot_vld[n] = 1'b0;
      words[n]    = '0;
      case (n)
        SL_CMD_ADDR: begin
          slot_vld[n] = snap_cmd_q;
          words[n]    = snap_cmd_q ? {snap_rd_q, snap_addr_q, {CMD_PAD_W{1'b0}}} : '0;
        end
        SL_CMD_DATA: begin
          slot_vld[n] = snap_cmd_q && !snap_rd_q;
          words[n]    = slot_vld[n] ? {snap_wd_q, {PAD_W{1'b0}}} : '0;
        end
        SL_LINE1: begin
          slot_vld[n] = 1'b1;
          words[n]    = {snap_l1_q, {PAD_W{1'b0}}};
        end
        SL_LINE2: begin
          slot_vld[n] = 1'b1;
          words[n]    = {snap_l2_q, {PAD_W{1'b0}}};
        end
        SL_GPIO: begin
          slot_vld[n] = 1'b1;
          words[n]    = {snap_gp_q, {PAD_W{1'b0}}};
        end
        default: ;
      endcase
    end
  end

  // tag slot: frame valid on top, then one flag per slot
  always_comb begin
    words[0]                = '0;
    words[0][TAG_W-1]       = 1'b1;
    for (int n = 1; n <= N_SLOTS; n++) words[0][TAG_W-1-n] = slot_vld[n];
  end

  assign bit_nxt = words[slot_idx][bit_idx];

  // R3: trailing pad of the command address slot is zero
  a_r3_cmd_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == SLOT_IDX_W'(SL_CMD_ADDR)) && (bit_idx < BIT_IDX_W'(CMD_PAD_W)) |-> !bit_nxt);

  // R4: a read frame sends nothing in the data slot
  a_r4_read_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == SLOT_IDX_W'(SL_CMD_DATA)) && snap_rd_q |-> !bit_nxt);

  // R7: unused slots stay silent
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx inside {4'd3, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9, 4'd11}) |-> !bit_nxt);

  // R10: a command frame is never followed directly by another
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    load && snap_cmd_q |=> !snap_cmd_q);

  // R8: snapshot holds still except at the frame boundary
  a_r8_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(snap_l1_q) && $stable(snap_cmd_q) && $stable(snap_gp_q));
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SMP_W-1:0]  cmd_wdata,
  input  logic [SMP_W-1:0]  line1_dac,
  input  logic [SMP_W-1:0]  line2_dac,
  input  logic [SMP_W-1:0]  gpio_word,
  output logic              cmd_ack,
  output logic              sync,
  output logic              sdata
);
  logic [1:0]            rst_pipe_q;
  logic                  rst_sync_n;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic [BIT_IDX_W-1:0]  bit_idx;
  logic                  frame_last, bit_nxt, cmd_in_frame;
  logic                  sync_d, sdata_d, ack_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  aclink_frame_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .frame_last (frame_last)
  );

  aclink_slot_mux u_mux (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load         (frame_last),
    .cmd_valid    (cmd_valid),
    .cmd_rd       (cmd_rd),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .line1_dac    (line1_dac),
    .line2_dac    (line2_dac),
    .gpio_word    (gpio_word),
    .slot_idx     (slot_idx),
    .bit_idx      (bit_idx),
    .bit_nxt      (bit_nxt),
    .cmd_in_frame (cmd_in_frame)
  );

  always_comb begin
    sync_d  = (slot_idx == '0);
    sdata_d = bit_nxt;
    ack_d   = frame_last && cmd_in_frame;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sync    <= 1'b0;
      sdata   <= 1'b0;
      cmd_ack <= 1'b0;
    end else begin
      sync    <= sync_d;
      sdata   <= sdata_d;
      cmd_ack <= ack_d;
    end
  end

  // R9: the acknowledge sits on the final bit, so a new frame starts next
  a_r9_ack_then_frame: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ack |=> $rose(sync));

  // R9: the acknowledge is a single-cycle pulse
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_ack |=> !cmd_ack);

  // R11: outputs quiet while in reset
  always_comb begin
    if (!rst_n) a_r11_reset_quiet: assert (!sync && !sdata && !cmd_ack);
  end
endmodule

// File: tb/tb_aclink_tx_framer.sv
`timescale 1ns/1ps
module tb_aclink_tx_framer;
  localparam int FRAMES = 9;

  typedef struct {
    logic [255:0] bits;
    logic         has_cmd;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0, line1_dac = '0, line2_dac = '0, gpio_word = '0;
  logic        cmd_ack, sync, sdata;

  int checks = 0, failures = 0;
  frame_t exp_q[$];
  logic   done = 1'b0;

  always #2.5 clk = ~clk;

  aclink_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .line1_dac(line1_dac),
    .line2_dac(line2_dac), .gpio_word(gpio_word),
    .cmd_ack(cmd_ack), .sync(sync), .sdata(sdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected frame from the requirements (R2..R7)
  function automatic frame_t build(input logic cmd, input logic rd, input logic [6:0] addr,
                                   input logic [15:0] wd, input logic [15:0] l1,
                                   input logic [15:0] l2, input logic [15:0] gp);
    frame_t f;
    logic [15:0] tag;
    logic [19:0] s1, s2;
    tag = 16'h8428 | (cmd ? 16'h4000 : 16'h0) | ((cmd && !rd) ? 16'h2000 : 16'h0);
    s1  = cmd ? {rd, addr, 12'h000} : 20'h0;
    s2  = (cmd && !rd) ? {wd, 4'h0} : 20'h0;
    f.bits = {tag, s1, s2, 20'h0, 20'h0, {l1, 4'h0}, 20'h0, 20'h0, 20'h0, 20'h0,
              {l2, 4'h0}, 20'h0, {gp, 4'h0}};
    f.has_cmd = cmd;
    return f;
  endfunction

  // driver: inputs for frame k+1 are set in the middle of frame k
  task automatic drive(input int k, inout logic prev_cmd);
    logic want, rd;
    logic [6:0] a;
    logic [15:0] wd, l1, l2, gp;
    logic took;
    want = 1'b0; rd = 1'b0; a = '0; wd = '0;
    l1 = 16'h1111 * 16'(k); l2 = ~(16'h0F0F + 16'(k)); gp = 16'(1) << k;
    case (k)
      1: begin want = 1; rd = 0; a = 7'h2A; wd = 16'hA5C3; l1 = 16'h1234; l2 = 16'hFEDC; end
      2: begin want = 1; rd = 0; a = 7'h2A; wd = 16'hA5C3; l1 = 16'h8000; end  // held: R10
      3: begin want = 1; rd = 1; a = 7'h7F; wd = 16'hFFFF; l1 = 16'h7FFF; l2 = 16'h0001; end
      4: begin want = 0; gp = 16'h8001; end
      5: begin want = 1; rd = 0; a = 7'h00; wd = 16'h0001; gp = 16'hFFFF; end
      6: begin want = 1; rd = 1; a = 7'h55; end                              // ignored: R10
      7: begin want = 0; l1 = 16'hFFFF; l2 = 16'hFFFF; end
      default: begin want = 1; rd = 1; a = 7'h01; end
    endcase
    took = want && !prev_cmd;
    @(negedge clk);
    cmd_valid = want; cmd_rd = rd; cmd_addr = a; cmd_wdata = wd;
    line1_dac = l1; line2_dac = l2; gpio_word = gp;
    exp_q.push_back(build(took, rd, a, wd, l1, l2, gp));
    prev_cmd = took;
  endtask

  initial begin : driver
    logic prev_cmd;
    prev_cmd = 1'b0;
    exp_q.push_back(build(0, 0, '0, '0, '0, '0, '0));   // R11: first frame is empty
    repeat (4) @(negedge clk);
    check("R11 reset sync", 32'(sync), 0);
    check("R11 reset sdata", 32'(sdata), 0);
    check("R11 reset ack", 32'(cmd_ack), 0);
    rst_n = 1'b1;
    for (int k = 1; k < FRAMES; k++) begin
      @(posedge sync);
      repeat (100) @(negedge clk);
      drive(k, prev_cmd);
    end
  end

  // monitor: collect each frame bit by bit and compare with the queue
  initial begin : monitor
    logic [255:0] got;
    logic [255:0] syn;
    logic [255:0] ack;
    frame_t e;
    logic prev_sync;
    prev_sync = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sync && !prev_sync) break;
      prev_sync = sync;
    end
    for (int f = 0; f < FRAMES; f++) begin
      for (int i = 0; i < 256; i++) begin
        if (i != 0) @(negedge clk);
        got[255-i] = sdata; syn[255-i] = sync; ack[255-i] = cmd_ack;
      end
      @(negedge clk);   // next frame's first bit is sampled in the next pass
      if (exp_q.size() == 0) begin
        check("R1 expected frame queued", 0, 1);
        continue;
      end
      e = exp_q.pop_front();
      check("R1 sync high for tag only", 32'(syn[255:224]), 32'hFFFF0000);
      check("R1 sync low in slots", 32'(syn[223:0] != '0), 0);
      check("R2 tag", 32'(got[255:240]), 32'(e.bits[255:240]));
      for (int s = 1; s <= 12; s++) begin
        int hi;
        string tagname;
        hi = 239 - 20 * (s - 1);
        case (s)
          1: tagname = "R3 slot1";
          2: tagname = "R4 slot2";
          5, 10: tagname = "R5 dac slot";
          12: tagname = "R6 gpio slot";
          default: tagname = "R7 unused slot";
        endcase
        check($sformatf("%s(%0d) frame %0d R8", tagname, s, f), 32'(got[hi -: 20]),
              32'(e.bits[hi -: 20]));
      end
      check($sformatf("R9 ack frame %0d R10", f), 32'(ack),
            e.has_cmd ? 32'h1 : 32'h0);
      check("R9 ack only at last bit", 32'(ack[255:1] != '0), 0);
      // re-align: this negedge is bit 0 of the next frame, step back one
      got = '0;
      if (f != FRAMES - 1) begin
        // current sample is bit 0 of the next frame
        got[255] = sdata;
      end
      // the loop re-samples bit 0 at i==0 without waiting
    end
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule